// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block turns 32-bit logical addresses into physical addresses for one access stream. It keeps a small cache of page descriptors, with 16 sets of 4 ways. Each request looks up the set picked by the low page-number bits and compares all four tags at once. On a hit it returns the translated address, the descriptor's 2-bit cache-mode field and a protection-fault flag, one cycle after the request. The fault flag is raised when a user access touches a supervisor-only page, or when any write touches a write-protected page.

On a miss the block asks an external table walker for the descriptor of the page. It stores the returned descriptor in the indexed set, filling invalid ways first and otherwise replacing ways in round-robin order per set, and then completes the stalled access with that descriptor. The page size can be switched between 4 KB and 8 KB at run time. A flush input empties the whole cache in one cycle. When translation is turned off, each logical address comes back unchanged with no permission check. This mode is meant for bring-up and debug.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid` and `walk_req_valid` are low, `req_ready` is high and every entry is invalid, so the first translated access of any page walks.
- R2: With `pg_large`=0 (4 KB pages) the set index is laddr[15:12], the tag is laddr[31:12] and the physical address is {pfn[19:0], laddr[11:0]}.
- R3: With `pg_large`=1 (8 KB pages) the set index is laddr[16:13], tags match on laddr[31:13] only, and the physical address is {pfn[19:1], laddr[12:0]}. The cache must be flushed whenever `pg_large` changes.
- R4: A translated access with `req_super`=0 to a page whose descriptor has `sup_only`=1 returns `rsp_fault`=1 with `rsp_paddr`=0 and `rsp_cmode`=0.
- R5: A translated access with `req_write`=1 to a page whose descriptor has `wprot`=1 faults in the same way, in both user and supervisor mode.
- R6: On a miss the block raises `walk_req_valid` with `walk_vpn`=laddr[31:12] and holds both until `walk_req_ready`. It then accepts one descriptor (`walk_rsp_valid` with `walk_rsp_ready`), installs it and responds from it. A later access to the same page hits with no walk.
- R7: With `xlate_en`=0 the response is `rsp_paddr`=`req_laddr`, `rsp_fault`=0 and `rsp_cmode`=0, one cycle after the request, with no walk and no cache change.
- R8: A hit, or an access with translation off, makes `rsp_valid` high in the cycle right after the request is accepted. A response that does not fault carries the descriptor's `cmode` field.
- R9: An install uses the lowest-numbered invalid way of the set. When the set is full it uses the set's round-robin pointer, which starts at way 0 and advances by one on each replacement of a valid entry.
- R10: One cycle with `flush`=1 invalidates all 64 entries, and flush wins over an install in the same cycle.
- R11: A response stays valid and stable until `rsp_ready` is high. `req_ready` is high only when no response is pending, or when the pending one is being taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | 1 = translate, 0 = pass logical address through |
| pg_large | input | 1 | 0 = 4 KB pages, 1 = 8 KB pages |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is in supervisor mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cmode | output | 2 | Cache-mode field of the descriptor |
| rsp_fault | output | 1 | Protection fault |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_vpn | output | 20 | Logical page number to walk (laddr[31:12]) |
| walk_rsp_valid | input | 1 | Walker descriptor valid |
| walk_rsp_ready | output | 1 | Block accepts descriptor |
| walk_pfn | input | 20 | Physical frame number at 4 KB granularity |
| walk_sup_only | input | 1 | Page is supervisor-only |
| walk_wprot | input | 1 | Page is write-protected |
| walk_cmode | input | 2 | Cache-mode field |

## Verification
The bench fills every set with six pages, then revisits them so that eviction order becomes visible as a pattern of walks. A wrong round-robin pointer, or filling ways that are already valid, shows up as a walk where a hit was due, or the other way round. It visits every combination of supervisor-only, write-protect, write and mode. A design that checks only one of the two rules, or leaves the address on the bus during a fault, gives a wrong fault flag or a nonzero address. In 8 KB mode it touches both 4 KB halves of each page. A design that keeps the small index or the full tag walks on the second half or returns the wrong offset bit 12. It also holds the consumer back to show that the response stays put, and it flushes and then expects a walk.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef struct packed {
      logic       sup_only;
      logic       wprot;
      logic [1:0] cmode;
   } tlb_attr_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WREQ,
      ST_WRSP,
      ST_RESP
   } tlb_state_e;

endpackage

// File: rtl/tlb_tag_store.sv
module tlb_tag_store
   import tlb_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int VPN_W = 20,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             pg_large,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [VPN_W-1:0] lk_pfn,
   output tlb_attr_t        lk_attr,
   input  logic [IDX_W-1:0] vc_idx,
   output logic [WAYS-1:0]  vc_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [VPN_W-1:0] wr_pfn,
   input  tlb_attr_t        wr_attr
);

   logic [SETS-1:0][WAYS-1:0] valid_q;
   logic [VPN_W-1:0]          tag_q  [SETS][WAYS];
   logic [VPN_W-1:0]          pfn_q  [SETS][WAYS];
   tlb_attr_t                 attr_q [SETS][WAYS];
   logic [WAYS-1:0]           way_hit;
   logic [VPN_W-1:0]          cmp_mask;

   // large pages ignore the lowest page-number bit
   assign cmp_mask = pg_large ? {{(VPN_W-1){1'b1}}, 1'b0} : {VPN_W{1'b1}};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w] = valid_q[lk_idx][w] &&
                          (((tag_q[lk_idx][w] ^ lk_vpn) & cmp_mask) == '0);
   end

   always_comb begin
      lk_pfn  = '0;
      lk_attr = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w]) begin
            lk_pfn  = pfn_q[lk_idx][w];
            lk_attr = attr_q[lk_idx][w];
         end
      end
   end

   assign lk_hit   = |way_hit;
   assign vc_valid = valid_q[vc_idx];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx][wr_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx][wr_way]  <= wr_vpn;
         pfn_q[wr_idx][wr_way]  <= wr_pfn;
         attr_q[wr_idx][wr_way] <= wr_attr;
      end
   end

   AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0)); // R10
   AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit)); // R6

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  valid_set,
   input  logic             take,
   output logic [WAY_W-1:0] way
);

   logic [WAY_W-1:0] ptr_q [SETS];
   logic [WAY_W-1:0] first_inv;
   logic             full;

   assign full = &valid_set;

   always_comb begin
      first_inv = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_set[w]) first_inv = WAY_W'(w);
      end
   end

   assign way = full ? ptr_q[idx] : first_inv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (take && full) begin
         ptr_q[idx] <= ptr_q[idx] + 1'b1;
      end
   end

   AST_FILL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !full) |-> !valid_set[way]); // R9

endmodule

// File: rtl/tlb_xform.sv
module tlb_xform
   import tlb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 12,
   parameter int PFN_W  = ADDR_W - OFF_W
) (
   input  logic              enable,
   input  logic              pg_large,
   input  logic              is_write,
   input  logic              is_super,
   input  logic [ADDR_W-1:0] laddr,
   input  logic [PFN_W-1:0]  pfn,
   input  tlb_attr_t         attr,
   output logic [ADDR_W-1:0] paddr,
   output logic [1:0]        cmode,
   output logic              fault
);

   logic [ADDR_W-1:0] pa_small;
   logic [ADDR_W-1:0] pa_large;
   logic              viol;

   assign pa_small = {pfn, laddr[OFF_W-1:0]};
   assign pa_large = {pfn[PFN_W-1:1], laddr[OFF_W:0]};
   assign viol     = (attr.sup_only && !is_super) || (attr.wprot && is_write);

   always_comb begin
      if (!enable) begin
         paddr = laddr;
         cmode = 2'b00;
         fault = 1'b0;
      end else if (viol) begin
         paddr = '0;
         cmode = 2'b00;
         fault = 1'b1;
      end else begin
         paddr = pg_large ? pa_large : pa_small;
         cmode = attr.cmode;
         fault = 1'b0;
      end
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 12,
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   localparam int VPN_W = ADDR_W - OFF_W,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlate_en,
   input  logic              pg_large,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic              req_write,
   input  logic              req_super,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [1:0]        rsp_cmode,
   output logic              rsp_fault,
   output logic              walk_req_valid,
   input  logic              walk_req_ready,
   output logic [VPN_W-1:0]  walk_vpn,
   input  logic              walk_rsp_valid,
   output logic              walk_rsp_ready,
   input  logic [VPN_W-1:0]  walk_pfn,
   input  logic              walk_sup_only,
   input  logic              walk_wprot,
   input  logic [1:0]        walk_cmode
);

   initial begin
      AST_CFG_SETS: assert (SETS == (1 << IDX_W)) else $fatal(1, "SETS must be a power of two");
      AST_CFG_WAYS: assert (WAYS == (1 << WAY_W) && WAYS > 1) else $fatal(1, "WAYS must be a power of two");
      AST_CFG_ADDR: assert (ADDR_W > OFF_W + 1 + IDX_W) else $fatal(1, "address too narrow");
   end

   tlb_state_e        state_q;
   logic [ADDR_W-1:0] q_laddr;
   logic              q_write, q_super, q_pg;
   logic [ADDR_W-1:0] rsp_paddr_q;
   logic [1:0]        rsp_cmode_q;
   logic              rsp_fault_q;

   logic              accept, sel_walk, install;
   logic [IDX_W-1:0]  lk_idx, q_idx;
   logic              lk_hit;
   logic [VPN_W-1:0]  lk_pfn;
   tlb_attr_t         lk_attr, walk_attr;
   logic [WAYS-1:0]   vc_valid;
   logic [WAY_W-1:0]  vc_way;

   logic              xf_en, xf_pg, xf_wr, xf_sup;
   logic [ADDR_W-1:0] xf_laddr, xf_paddr;
   logic [VPN_W-1:0]  xf_pfn;
   tlb_attr_t         xf_attr;
   logic [1:0]        xf_cmode;
   logic              xf_fault;

   assign req_ready      = (state_q == ST_IDLE) || (state_q == ST_RESP && rsp_ready);
   assign accept         = req_valid && req_ready;
   assign rsp_valid      = (state_q == ST_RESP);
   assign walk_req_valid = (state_q == ST_WREQ);
   assign walk_rsp_ready = (state_q == ST_WRSP);
   assign walk_vpn       = q_laddr[ADDR_W-1:OFF_W];
   assign sel_walk       = (state_q == ST_WRSP);
   assign install        = sel_walk && walk_rsp_valid;
   assign walk_attr      = '{sup_only: walk_sup_only, wprot: walk_wprot, cmode: walk_cmode};

   assign lk_idx = pg_large ? req_laddr[OFF_W+1 +: IDX_W] : req_laddr[OFF_W +: IDX_W];
   assign q_idx  = q_pg     ? q_laddr[OFF_W+1 +: IDX_W]   : q_laddr[OFF_W +: IDX_W];

   assign xf_en    = sel_walk || xlate_en;
   assign xf_pg    = sel_walk ? q_pg    : pg_large;
   assign xf_wr    = sel_walk ? q_write : req_write;
   assign xf_sup   = sel_walk ? q_super : req_super;
   assign xf_laddr = sel_walk ? q_laddr : req_laddr;
   assign xf_pfn   = sel_walk ? walk_pfn : lk_pfn;
   assign xf_attr  = sel_walk ? walk_attr : lk_attr;

   tlb_tag_store #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .pg_large (pg_large),
      .lk_idx   (lk_idx),
      .lk_vpn   (req_laddr[ADDR_W-1:OFF_W]),
      .lk_hit   (lk_hit),
      .lk_pfn   (lk_pfn),
      .lk_attr  (lk_attr),
      .vc_idx   (q_idx),
      .vc_valid (vc_valid),
      .wr_en    (install),
      .wr_idx   (q_idx),
      .wr_way   (vc_way),
      .wr_vpn   (walk_vpn),
      .wr_pfn   (walk_pfn),
      .wr_attr  (walk_attr)
   );

   tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (q_idx),
      .valid_set (vc_valid),
      .take      (install),
      .way       (vc_way)
   );

   tlb_xform #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_xform (
      .enable   (xf_en),
      .pg_large (xf_pg),
      .is_write (xf_wr),
      .is_super (xf_sup),
      .laddr    (xf_laddr),
      .pfn      (xf_pfn),
      .attr     (xf_attr),
      .paddr    (xf_paddr),
      .cmode    (xf_cmode),
      .fault    (xf_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         q_laddr     <= '0;
         q_write     <= 1'b0;
         q_super     <= 1'b0;
         q_pg        <= 1'b0;
         rsp_paddr_q <= '0;
         rsp_cmode_q <= '0;
         rsp_fault_q <= 1'b0;
      end else if (accept) begin
         q_laddr <= req_laddr;
         q_write <= req_write;
         q_super <= req_super;
         q_pg    <= pg_large;
         if (!xlate_en || lk_hit) begin
            rsp_paddr_q <= xf_paddr;
            rsp_cmode_q <= xf_cmode;
            rsp_fault_q <= xf_fault;
            state_q     <= ST_RESP;
         end else begin
            state_q <= ST_WREQ;
         end
      end else begin
         case (state_q)
            ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
            ST_WREQ: if (walk_req_ready) state_q <= ST_WRSP;
            ST_WRSP: if (walk_rsp_valid) begin
               rsp_paddr_q <= xf_paddr;
               rsp_cmode_q <= xf_cmode;
               rsp_fault_q <= xf_fault;
               state_q     <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_paddr = rsp_paddr_q;
   assign rsp_cmode = rsp_cmode_q;
   assign rsp_fault = rsp_fault_q;

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R11
   AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_vpn))); // R6
   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !xlate_en) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr))); // R7
   AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && xlate_en && lk_hit) |=> rsp_valid); // R8
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cmode == 2'b00)); // R4

endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlate_en = 1'b0, pg_large = 1'b0, flush = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
   logic [31:0] req_laddr = '0;
   logic        req_ready, rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_cmode;
   logic        rsp_fault;
   logic        walk_req_valid, walk_rsp_ready;
   logic        walk_req_ready = 1'b0, walk_rsp_valid = 1'b0;
   logic [19:0] walk_vpn;
   logic [19:0] walk_pfn = '0;
   logic        walk_sup_only = 1'b0, walk_wprot = 1'b0;
   logic [1:0]  walk_cmode = '0;

   int errors = 0, checks = 0, walks = 0;
   bit done = 0;

   bit          mv [16][4];
   logic [19:0] mt [16][4];
   int          mp [16];

   always #2.5 clk = ~clk;

   tlb_xlate dut (.*);

   function automatic logic [19:0] d_pfn(input logic [19:0] v); return v ^ 20'h5A5A4; endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < 16; s++) begin
         mp[s] = 0;
         for (int w = 0; w < 4; w++) mv[s][w] = 0;
      end
   endtask

   // walker: accepts one cycle late, answers two cycles later
   initial begin
      logic [19:0] v;
      forever begin
         @(negedge clk);
         if (walk_req_valid) begin
            @(negedge clk);
            walk_req_ready = 1'b1;
            v = walk_vpn;
            @(negedge clk);
            walk_req_ready = 1'b0;
            walks++;
            repeat (2) @(negedge clk);
            walk_pfn      = d_pfn(v);
            walk_sup_only = v[5];
            walk_wprot    = v[6];
            walk_cmode    = v[8:7];
            walk_rsp_valid = 1'b1;
            @(negedge clk);
            walk_rsp_valid = 1'b0;
         end
      end
   end

   task automatic access(input logic [31:0] la, input bit wr, input bit sp, input string rq);
      int s, lat, w0, vw;
      bit hit, ef, full;
      logic [19:0] vpn, pfn;
      logic [31:0] ep;
      logic [1:0] ec;
      vpn = la[31:12];
      s = pg_large ? int'(la[16:13]) : int'(la[15:12]);
      hit = 0;
      for (int w = 0; w < 4; w++)
         if (mv[s][w] && (pg_large ? (mt[s][w][19:1] == vpn[19:1]) : (mt[s][w] == vpn))) hit = 1;
      pfn = d_pfn(vpn);
      if (!xlate_en) begin
         ep = la; ec = 2'b00; ef = 0;
      end else if ((vpn[5] && !sp) || (vpn[6] && wr)) begin
         ep = '0; ec = 2'b00; ef = 1;
      end else begin
         ep = pg_large ? {pfn[19:1], la[12:0]} : {pfn, la[11:0]};
         ec = vpn[8:7]; ef = 0;
      end
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la; req_write = wr; req_super = sp;
      w0 = walks;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      chk(rsp_paddr == ep, {rq, " paddr"}, rsp_paddr, ep);
      chk(rsp_fault == ef, {rq, " fault"}, 32'(rsp_fault), 32'(ef));
      chk(rsp_cmode == ec, {rq, " cmode"}, 32'(rsp_cmode), 32'(ec));
      chk((walks - w0) == ((xlate_en && !hit) ? 1 : 0), {rq, " walk count (R6 R9)"},
          32'(walks - w0), 32'((xlate_en && !hit) ? 1 : 0));
      if (!xlate_en || hit) chk(lat == 1, {rq, " latency R8"}, 32'(lat), 32'd1);
      if (xlate_en && !hit) begin
         full = 1; vw = 0;
         for (int w = 3; w >= 0; w--) if (!mv[s][w]) begin full = 0; vw = w; end
         if (full) begin vw = mp[s]; mp[s] = (mp[s] + 1) % 4; end
         mv[s][vw] = 1; mt[s][vw] = vpn;
      end
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      model_clear();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
      chk(walk_req_valid == 0, "R1 walk_req_valid", 32'(walk_req_valid), 0);
      chk(req_ready == 1, "R1 req_ready", 32'(req_ready), 1);

      // translation off
      for (int i = 0; i < 8; i++)
         access(32'h1234_5000 + 32'(i * 32'h0102_0467), i[0], i[1], "R7");

      // back-pressure on the response
      rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_laddr = 32'hCAFE_0123; req_write = 0; req_super = 0;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      held = rsp_paddr;
      chk(rsp_valid == 1, "R11 valid", 32'(rsp_valid), 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(rsp_valid == 1 && rsp_paddr == held, "R11 hold", rsp_paddr, held);
         chk(req_ready == 0, "R11 req_ready", 32'(req_ready), 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 0, "R11 drain", 32'(rsp_valid), 0);

      // 4 KB pages: six pages per set, then revisit
      xlate_en = 1'b1;
      for (int pass = 0; pass < 2; pass++)
         for (int s = 0; s < 16; s++)
            for (int k = 0; k < 6; k++)
               access((32'(k) << 16) | (32'(s) << 12) | 32'((s * 37 + k * 5) & 12'hfff), 0, 1,
                      pass == 0 ? "R2" : "R9");

      // permissions
      do_flush();
      for (int a = 0; a < 4; a++)
         for (int c = 0; c < 4; c++)
            access(32'h3000_0000 | (32'(a) << 17) | 32'(c * 8), c[0], c[1], a[0] ? "R4" : "R5");

      // flush empties the cache
      access(32'h3000_0010, 0, 1, "R10 before");
      do_flush();
      access(32'h3000_0010, 0, 1, "R10 after");

      // 8 KB pages
      pg_large = 1'b1;
      do_flush();
      for (int s = 0; s < 16; s++)
         for (int k = 0; k < 5; k++) begin
            access((32'(k) << 17) | (32'(s) << 13) | 32'(s * 11), 0, 1, "R3");
            access((32'(k) << 17) | (32'(s) << 13) | 32'h1000 | 32'(k * 3), 0, 1, "R3 upper half");
         end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule